// File: doc/BRIEF.md
# ATA Power Mode Controller

This block holds the power state of a storage device and runs the power commands that a host sends to it. The states are active, idle, standby, sleep and device sleep. A command front end hands the block a decoded opcode and the 8-bit sector-count value. Each accepted command raises a busy flag for one cycle and then finishes with a one-cycle interrupt pulse. The power-state query returns a status byte that reports the current state.

The idle command also sets up an automatic timer. A non-zero sector count arms the timer with a period of that many tick pulses. A zero count turns it off. While the device sits idle with no host traffic, the timer counts down and then moves the device to standby without an interrupt.

A device-sleep pin, enabled by a separate input, forces the lowest-power state for as long as it is held. Sleep entered by command can be left only through reset.

Top module: `pmc_top`

## Requirements
- R1: After reset, mode is 0 (active), busy, intr and cmd_err are low, pm_result is 00h and the standby timer is disabled. The mode codes are 0 active, 1 idle, 2 standby, 3 sleep and 4 device sleep.
- R2: A command is accepted when cmd_valid is high, busy is low and the mode is active, idle or standby. Busy is then high for exactly the next cycle. In the cycle after that, intr is high for one cycle with busy low, and the new mode is already visible.
- R3: Opcode E1h moves the device to idle and restarts the countdown with the stored period. Opcodes E0h and E2h move it to standby and leave the timer setting unchanged.
- R4: Opcode E3h moves the device to idle. A non-zero count N arms the timer with a period of N tick pulses. A count of 0 disables the timer, and the device then stays idle however many ticks arrive.
- R5: While idle and not busy, with the timer armed, the device moves to standby on the edge that samples the N-th tick since the countdown last restarted. No interrupt is raised for this move.
- R6: host_act in idle restarts the countdown, and that cycle's tick is not counted. host_act in standby moves the device to active. host_act has no effect while busy.
- R7: Opcode E5h leaves the mode unchanged. In the intr cycle it sets pm_result to FFh if the mode is active, 80h if idle and 00h if standby. pm_result holds that value until the next E5h completes.
- R8: Opcode E6h moves the device to sleep. In sleep, commands, host_act and the device-sleep pin have no effect until reset.
- R9: With devslp_en and devslp_pin both high and the mode not sleep, the next edge sets mode 4 and abandons any pending command, with no intr. Commands are ignored in mode 4. When the request drops, the next edge sets mode 1 (idle) and restarts the countdown.
- R10: With devslp_en low, devslp_pin has no effect.
- R11: Opcode 00h (NOP) and every opcode not listed above complete the handshake with cmd_err high in the intr cycle and the mode unchanged.
- R12: cmd_valid while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| cmd_count | input | 8 | Sector-count value of the command |
| host_act | input | 1 | Host activity strobe |
| tick | input | 1 | Standby timer time base pulse |
| devslp_en | input | 1 | Enables the device-sleep pin |
| devslp_pin | input | 1 | Device-sleep request, active high |
| busy | output | 1 | Command in progress |
| intr | output | 1 | Command completion pulse |
| cmd_err | output | 1 | Command aborted, valid with intr |
| pm_result | output | 8 | Power-state query result |
| mode | output | 3 | Current power mode code |

## Verification
A wrong handshake state shows up within one cycle: busy stays high for a second cycle, or intr appears without busy before it. A bad countdown value shows up as a move to standby one or more ticks early or late, so the bench compares the mode on every cycle against a behavioural model while it drives tick runs both with and without host activity. A stale mode is also exposed by the query byte at the next E5h. A lost device-sleep priority shows up as a stray interrupt, or as the device failing to return to idle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        PM_ACTIVE  = 3'd0,
        PM_IDLE    = 3'd1,
        PM_STANDBY = 3'd2,
        PM_SLEEP   = 3'd3,
        PM_DEVSLP  = 3'd4
    } pm_mode_t;

    typedef enum logic [2:0] {
        K_ABORT,
        K_IDLE_NOW,
        K_IDLE_TMR,
        K_STANDBY,
        K_SLEEP,
        K_QUERY
    } cmd_kind_t;

    localparam logic [7:0] OP_STBY_NOW = 8'hE0;
    localparam logic [7:0] OP_IDLE_NOW = 8'hE1;
    localparam logic [7:0] OP_STBY     = 8'hE2;
    localparam logic [7:0] OP_IDLE     = 8'hE3;
    localparam logic [7:0] OP_QUERY    = 8'hE5;
    localparam logic [7:0] OP_SLEEP    = 8'hE6;

    function automatic logic [7:0] query_code(pm_mode_t m);
        case (m)
            PM_ACTIVE: return 8'hFF;
            PM_IDLE:   return 8'h80;
            default:   return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/pmc_decode.sv
module pmc_decode
    import pmc_pkg::*;
(
    input  logic [7:0] op,
    output cmd_kind_t  kind
);
    always_comb begin
        case (op)
            OP_STBY_NOW, OP_STBY: kind = K_STANDBY;
            OP_IDLE_NOW:          kind = K_IDLE_NOW;
            OP_IDLE:              kind = K_IDLE_TMR;
            OP_QUERY:             kind = K_QUERY;
            OP_SLEEP:             kind = K_SLEEP;
            default:              kind = K_ABORT;
        endcase
    end
endmodule

// File: rtl/pmc_timer.sv
module pmc_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         prog,
    input  logic [W-1:0] prog_val,
    input  logic         reload,
    input  logic         run,
    input  logic         tick,
    output logic         last
);
    typedef struct packed {
        logic         en;
        logic [W-1:0] period;
        logic [W-1:0] left;
    } tmr_t;

    localparam logic [W-1:0] ONE = W'(1);

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (prog) begin
            t_d.en     = (prog_val != '0);
            t_d.period = prog_val;
            t_d.left   = prog_val;
        end else if (reload) begin
            t_d.left = t_q.period;
        end else if (run && tick && t_q.en) begin
            t_d.left = (t_q.left == ONE) ? t_q.period : t_q.left - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign last = t_q.en && (t_q.left == ONE);
endmodule

// File: rtl/pmc_top.sv
module pmc_top
    import pmc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_op,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic             host_act,
    input  logic             tick,
    input  logic             devslp_en,
    input  logic             devslp_pin,
    output logic             busy,
    output logic             intr,
    output logic             cmd_err,
    output logic [7:0]       pm_result,
    output logic [2:0]       mode
);
    typedef struct packed {
        pm_mode_t         mode;
        logic             busy;
        logic             intr;
        logic             err;
        logic [7:0]       res;
        cmd_kind_t        kind;
        logic [CNT_W-1:0] count;
    } st_t;

    st_t       s_d, s_q;
    cmd_kind_t dec_kind;
    logic      t_prog, t_reload, t_run, t_last;
    logic      ds_req, can_take;

    pmc_decode u_dec (
        .op   (cmd_op),
        .kind (dec_kind)
    );

    pmc_timer #(.W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog     (t_prog),
        .prog_val (s_q.count),
        .reload   (t_reload),
        .run      (t_run),
        .tick     (tick),
        .last     (t_last)
    );

    assign ds_req   = devslp_en && devslp_pin && (s_q.mode != PM_SLEEP);
    assign can_take = (s_q.mode == PM_ACTIVE) || (s_q.mode == PM_IDLE) ||
                      (s_q.mode == PM_STANDBY);

    always_comb begin
        s_d      = s_q;
        s_d.intr = 1'b0;
        s_d.err  = 1'b0;
        t_prog   = 1'b0;
        t_reload = 1'b0;
        t_run    = 1'b0;
        if (ds_req) begin
            s_d.mode = PM_DEVSLP;
            s_d.busy = 1'b0;
        end else if (s_q.mode == PM_DEVSLP) begin
            s_d.mode = PM_IDLE;
            t_reload = 1'b1;
        end else if (s_q.busy) begin
            s_d.busy = 1'b0;
            s_d.intr = 1'b1;
            case (s_q.kind)
                K_IDLE_NOW: begin
                    s_d.mode = PM_IDLE;
                    t_reload = 1'b1;
                end
                K_IDLE_TMR: begin
                    s_d.mode = PM_IDLE;
                    t_prog   = 1'b1;
                end
                K_STANDBY: s_d.mode = PM_STANDBY;
                K_SLEEP:   s_d.mode = PM_SLEEP;
                K_QUERY:   s_d.res  = query_code(s_q.mode);
                default:   s_d.err  = 1'b1;
            endcase
        end else if (cmd_valid && can_take) begin
            s_d.busy  = 1'b1;
            s_d.kind  = dec_kind;
            s_d.count = cmd_count;
        end else if (s_q.mode == PM_IDLE) begin
            if (host_act) begin
                t_reload = 1'b1;
            end else begin
                t_run = 1'b1;
                if (tick && t_last) s_d.mode = PM_STANDBY;
            end
        end else if (s_q.mode == PM_STANDBY && host_act) begin
            s_d.mode = PM_ACTIVE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.mode  <= PM_ACTIVE;
            s_q.kind  <= K_ABORT;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = s_q.busy;
    assign intr      = s_q.intr;
    assign cmd_err   = s_q.err;
    assign pm_result = s_q.res;
    assign mode      = s_q.mode;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       intr,
    input logic       cmd_err,
    input logic       devslp_en,
    input logic       devslp_pin,
    input logic [2:0] mode
);
    assert_busy_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    assert_intr_follows_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> ($past(busy) && !busy));

    assert_err_with_intr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> intr);

    assert_sleep_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3) |=> (mode == 3'd3));

    assert_devslp_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4 && !(devslp_en && devslp_pin)) |=> (mode == 3'd1));

    assert_devslp_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !devslp_en |=> (mode != 3'd4));

    assert_timer_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2 && $past(mode) == 3'd1 && !$past(busy)) |-> !intr);
endmodule

bind pmc_top pmc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .intr       (intr),
    .cmd_err    (cmd_err),
    .devslp_en  (devslp_en),
    .devslp_pin (devslp_pin),
    .mode       (mode)
);

// File: tb/pmc_top_test.sv
module pmc_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_op = 8'h00;
    logic [7:0] cmd_count = 8'h00;
    logic       host_act = 1'b0;
    logic       tick = 1'b0;
    logic       devslp_en = 1'b0;
    logic       devslp_pin = 1'b0;
    logic       busy, intr, cmd_err;
    logic [7:0] pm_result;
    logic [2:0] mode;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    pmc_top uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_count(cmd_count), .host_act(host_act), .tick(tick),
        .devslp_en(devslp_en), .devslp_pin(devslp_pin), .busy(busy),
        .intr(intr), .cmd_err(cmd_err), .pm_result(pm_result), .mode(mode)
    );

    // behavioural reference model
    int m_mode, m_busy, m_intr, m_err, m_res, p_op, p_cnt;
    int t_on, t_per, t_left;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_busy = 0; m_intr = 0; m_err = 0; m_res = 0;
            p_op = 0; p_cnt = 0; t_on = 0; t_per = 0; t_left = 0;
        end else begin
            m_intr = 0;
            m_err  = 0;
            if (devslp_en && devslp_pin && m_mode != 3) begin
                m_mode = 4; m_busy = 0;
            end else if (m_mode == 4) begin
                m_mode = 1; t_left = t_per;
            end else if (m_busy == 1) begin
                m_busy = 0; m_intr = 1;
                if (p_op == 'hE1) begin m_mode = 1; t_left = t_per; end
                else if (p_op == 'hE3) begin
                    t_on = (p_cnt != 0); t_per = p_cnt; t_left = p_cnt; m_mode = 1;
                end
                else if (p_op == 'hE0 || p_op == 'hE2) m_mode = 2;
                else if (p_op == 'hE6) m_mode = 3;
                else if (p_op == 'hE5) m_res = (m_mode == 0) ? 'hFF : (m_mode == 1) ? 'h80 : 0;
                else m_err = 1;
            end else if (cmd_valid && m_mode <= 2) begin
                m_busy = 1; p_op = cmd_op; p_cnt = cmd_count;
            end else if (m_mode == 1 && host_act) begin
                t_left = t_per;
            end else if (m_mode == 2 && host_act) begin
                m_mode = 0;
            end else if (m_mode == 1 && tick && t_on) begin
                if (t_left == 1) begin m_mode = 2; t_left = t_per; end
                else t_left = t_left - 1;
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check({cur_req, " mode"}, int'(mode), m_mode);
            check({cur_req, " busy"}, int'(busy), m_busy);
            check({cur_req, " intr"}, int'(intr), m_intr);
            check({cur_req, " cmd_err"}, int'(cmd_err), m_err);
            check({cur_req, " pm_result"}, int'(pm_result), m_res);
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // accepted command with explicit handshake checks (R2)
    task automatic cmd(logic [7:0] op, logic [7:0] cnt);
        cmd_valid = 1'b1; cmd_op = op; cmd_count = cnt;
        step(1);
        cmd_valid = 1'b0;
        check("R2 busy after accept", int'(busy), 1);
        step(1);
        check("R2 intr after busy", int'(intr), 1);
        check("R2 busy low in intr cycle", int'(busy), 0);
    endtask

    task automatic poke(logic [7:0] op);
        cmd_valid = 1'b1; cmd_op = op; cmd_count = 8'h05;
        step(1);
        cmd_valid = 1'b0;
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        check("R1 reset mode", int'(mode), 0);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset intr", int'(intr), 0);
        check("R1 reset result", int'(pm_result), 0);
        rst_n = 1'b1;
        cur_req = "R1"; tick = 1'b1; step(5); tick = 1'b0;
        check("R1 timer off after reset", int'(mode), 0);

        cur_req = "R7";
        cmd(8'hE5, 0); check("R7 active code", int'(pm_result), 'hFF);
        cur_req = "R3";
        cmd(8'hE1, 0); check("R3 idle now", int'(mode), 1);
        cur_req = "R7";
        cmd(8'hE5, 0); check("R7 idle code", int'(pm_result), 'h80);
        cur_req = "R3";
        cmd(8'hE0, 0); check("R3 standby now", int'(mode), 2);
        cur_req = "R7";
        cmd(8'hE5, 0); check("R7 standby code", int'(pm_result), 'h00);
        check("R7 mode kept", int'(mode), 2);
        cur_req = "R6";
        host_act = 1'b1; step(1); host_act = 1'b0;
        check("R6 standby to active", int'(mode), 0);

        cur_req = "R5";
        cmd(8'hE3, 3); check("R4 idle with timer", int'(mode), 1);
        tick = 1'b1; step(2); check("R5 not yet", int'(mode), 1);
        step(1); tick = 1'b0;
        check("R5 auto standby", int'(mode), 2);
        check("R5 no intr", int'(intr), 0);

        cur_req = "R6";
        cmd(8'hE3, 4);
        tick = 1'b1; step(2);
        tick = 1'b1; host_act = 1'b1; step(1); host_act = 1'b0;
        step(3); check("R6 restart held idle", int'(mode), 1);
        step(1); tick = 1'b0;
        check("R6 standby after restart", int'(mode), 2);
        host_act = 1'b1; step(1); host_act = 1'b0;

        cur_req = "R3";
        cmd(8'hE2, 0); check("R3 standby", int'(mode), 2);
        cmd(8'hE1, 0);
        tick = 1'b1; step(4); tick = 1'b0;
        check("R3 timer kept after standby", int'(mode), 2);

        cur_req = "R4";
        cmd(8'hE3, 0);
        tick = 1'b1; step(20); tick = 1'b0;
        check("R4 zero count disables", int'(mode), 1);
        cmd(8'hE3, 1);
        tick = 1'b1; step(1); tick = 1'b0;
        check("R4 period one", int'(mode), 2);

        cur_req = "R11";
        cmd(8'h00, 0); check("R11 nop err", int'(cmd_err), 1);
        check("R11 mode kept", int'(mode), 2);
        cmd(8'h55, 0); check("R11 unknown err", int'(cmd_err), 1);

        cur_req = "R12";
        cmd_valid = 1'b1; cmd_op = 8'hE1; step(2); cmd_valid = 1'b0;
        check("R12 second strobe dropped", int'(busy), 0);
        check("R12 first completes", int'(intr), 1);
        step(1); check("R12 no extra busy", int'(busy), 0);

        cur_req = "R10";
        devslp_pin = 1'b1; step(3);
        check("R10 pin ignored", int'(mode), 1);
        cur_req = "R9";
        devslp_en = 1'b1; step(1);
        check("R9 enter devslp", int'(mode), 4);
        poke(8'hE0); step(1);
        check("R9 cmd ignored", int'(busy), 0);
        devslp_pin = 1'b0; step(1);
        check("R9 exit to idle", int'(mode), 1);
        cmd(8'hE0, 0);
        cmd_valid = 1'b1; cmd_op = 8'hE1; step(1); cmd_valid = 1'b0;
        devslp_pin = 1'b1; step(1);
        check("R9 pending dropped", int'(intr), 0);
        check("R9 devslp over busy", int'(mode), 4);
        devslp_pin = 1'b0; step(2);

        cur_req = "R8";
        cmd(8'hE6, 0); check("R8 sleep", int'(mode), 3);
        poke(8'hE1); host_act = 1'b1; devslp_pin = 1'b1; step(3);
        host_act = 1'b0; devslp_pin = 1'b0;
        check("R8 sleep held", int'(mode), 3);
        check("R8 no busy", int'(busy), 0);
        rst_n = 1'b0; step(1); rst_n = 1'b1;
        check("R8 reset leaves sleep", int'(mode), 0);
        step(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule